// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers a wide vector of level-sensitive interrupt sources and folds them, eight at a time, into one interrupt line per group. Each group line is meant to feed one input of a parent interrupt controller. Software controls which sources may contribute, and the parent's handler then reads a status word to see which enabled sources are active.

Four groups share one 32-bit register bank. Each group owns one byte lane of that bank. The banks are laid out one after another, 0x10 bytes apart. Inside a bank there is a word for turning enables on and a word for turning them off, each written with ones to act. A third word reports the active enabled sources.

Because the set and clear words act only on the bits written as one, software can change one group's enables without reading first and without disturbing the other three groups in the same word. The number of groups is a parameter. When it is not a multiple of four, the last bank carries only the lanes that exist.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0. Every status word reads 0 and every group line is low, even with all sources held high.
- R2: Writing a word to bank offset 0x0 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged. A read of offset 0x0 or 0x4 returns the bank's current enable word.
- R3: Writing a word to bank offset 0x4 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: A read of bank offset 0xC returns, bit for bit, source input AND enable for the bank's 32 bits. Group g sits in bank g/4 (base address (g/4)*0x10), in bits [(g%4)*8 +: 8]. Global source number g*8+i is input bit src_in[g*8+i].
- R5: Group line g is registered. On each clock edge it takes the OR over its eight bits of (source AND enable), using the enables as they stand after any write at that same edge. A source change between edges does not reach the line before the next edge.
- R6: Sources are level-sensitive. A group line stays high on every edge for as long as an enabled source is held high. It falls at the first edge after the last enabled source drops.
- R7: One write of 0xFF shifted left by (g%4)*8 to offset 0x4 disables all eight sources of group g. The other three groups of that bank keep their enables.
- R8: Each group drives its own line. Activity in one group never raises another group's line.
- R9: All of the following read 0: offset 0x8, any address whose low two bits are not 00, and any bank index at or beyond the number of banks. Writes to those addresses have no effect. Writes to offset 0xC have no effect on the enables.
- R10: In a partly filled last bank, enable bits for lanes without a group read 0 and cannot be set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_in | input | NUM_GROUPS*8 | Raw level-sensitive interrupt sources |
| grp_irq | output | NUM_GROUPS | One registered interrupt line per group |

## Verification
The bench builds the combiner with NUM_GROUPS = 6 and ADDR_W = 6.

Six groups leave the second bank half filled, so the lane limit of R10 can be tested. The 6-bit address gives four bank indices, so banks 2 and 3 can be addressed even though they do not exist, which tests the out-of-range decode of R9. Two banks also let the bench show that writes and sources in one bank leave the other bank's lines and enables alone.

// File: rtl/combiner_pkg.sv
package combiner_pkg;
    localparam int          GRP_SIZE       = 8;
    localparam int          LANES_PER_BANK = 4;
    localparam int          BANK_BITS      = GRP_SIZE * LANES_PER_BANK;
    localparam logic [3:0]  OFF_SET        = 4'h0;
    localparam logic [3:0]  OFF_CLR        = 4'h4;
    localparam logic [3:0]  OFF_STAT       = 4'hC;
endpackage

// File: rtl/combiner_regdec.sv
module combiner_regdec
    import combiner_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    output logic [NUM_BANKS-1:0] hit,
    output logic [NUM_BANKS-1:0] set_sel,
    output logic [NUM_BANKS-1:0] clr_sel,
    output logic                 rd_en_sel,
    output logic                 rd_st_sel
);
    localparam int BW = ADDR_W - 4;

    logic [3:0] off;

    always_comb begin
        off       = addr[3:0];
        rd_en_sel = (off == OFF_SET) || (off == OFF_CLR);
        rd_st_sel = (off == OFF_STAT);
        for (int b = 0; b < NUM_BANKS; b++) begin
            hit[b]     = (addr[ADDR_W-1:4] == BW'(b));
            set_sel[b] = hit[b] && wr && (off == OFF_SET);
            clr_sel[b] = hit[b] && wr && (off == OFF_CLR);
        end
    end
endmodule

// File: rtl/combiner_bank.sv
module combiner_bank
    import combiner_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_stb,
    input  logic                      clr_stb,
    input  logic [LANES*GRP_SIZE-1:0] wdata,
    input  logic [LANES*GRP_SIZE-1:0] src,
    output logic [BANK_BITS-1:0]      en_word,
    output logic [BANK_BITS-1:0]      stat_word,
    output logic [LANES-1:0]          irq
);
    localparam int W = LANES * GRP_SIZE;

    typedef struct packed {
        logic [W-1:0]     en;
        logic [LANES-1:0] irq;
    } bank_state_t;

    bank_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_stb) s_d.en = s_q.en | wdata;
        if (clr_stb) s_d.en = s_d.en & ~wdata;
        for (int l = 0; l < LANES; l++) begin
            s_d.irq[l] = |(src[l*GRP_SIZE +: GRP_SIZE] & s_d.en[l*GRP_SIZE +: GRP_SIZE]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_word   = BANK_BITS'(s_q.en);
    assign stat_word = BANK_BITS'(src & s_q.en);
    assign irq       = s_q.irq;

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((s_q.en & $past(wdata)) == $past(wdata)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((s_q.en & $past(wdata)) == '0));

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(s_q.en));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R5
        irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (s_q.irq[l] ==
                |($past(src[l*GRP_SIZE +: GRP_SIZE]) & s_q.en[l*GRP_SIZE +: GRP_SIZE])));
    end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [31:0]                    reg_wdata,
    input  logic                           reg_wr,
    output logic [31:0]                    reg_rdata,
    input  logic [NUM_GROUPS*GRP_SIZE-1:0] src_in,
    output logic [NUM_GROUPS-1:0]          grp_irq
);
    localparam int NUM_BANKS = (NUM_GROUPS + LANES_PER_BANK - 1) / LANES_PER_BANK;

    logic [NUM_BANKS-1:0] hit, set_sel, clr_sel;
    logic                 rd_en_sel, rd_st_sel;
    logic [31:0]          bank_en   [NUM_BANKS];
    logic [31:0]          bank_stat [NUM_BANKS];

    combiner_regdec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr      (reg_addr),
        .wr        (reg_wr),
        .hit       (hit),
        .set_sel   (set_sel),
        .clr_sel   (clr_sel),
        .rd_en_sel (rd_en_sel),
        .rd_st_sel (rd_st_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LN = ((NUM_GROUPS - b*LANES_PER_BANK) >= LANES_PER_BANK)
                            ? LANES_PER_BANK : (NUM_GROUPS - b*LANES_PER_BANK);
        combiner_bank #(.LANES(LN)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_stb   (set_sel[b]),
            .clr_stb   (clr_sel[b]),
            .wdata     (reg_wdata[LN*GRP_SIZE-1:0]),
            .src       (src_in[b*BANK_BITS +: LN*GRP_SIZE]),
            .en_word   (bank_en[b]),
            .stat_word (bank_stat[b]),
            .irq       (grp_irq[b*LANES_PER_BANK +: LN])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit[b] && rd_en_sel) reg_rdata = reg_rdata | bank_en[b];
            if (hit[b] && rd_st_sel) reg_rdata = reg_rdata | bank_stat[b];
        end
    end

    // R9
    unused_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[3:0] != OFF_SET && reg_addr[3:0] != OFF_CLR && reg_addr[3:0] != OFF_STAT)
        |-> (reg_rdata == '0));
endmodule

// File: tb/irq_group_combiner_tb.sv
module irq_group_combiner_tb;
    localparam int NG = 6;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_rdata;
    logic [NG*8-1:0] src_in = '0;
    logic [NG-1:0] grp_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .src_in(src_in), .grp_irq(grp_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic clean;
        @(negedge clk);
        src_in = '0;
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h14, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        src_in = '1;
        step();
        rd(6'h00, v); check("R1 bank0 enables", v, 32'h0);
        rd(6'h10, v); check("R1 bank1 enables", v, 32'h0);
        rd(6'h0C, v); check("R1 bank0 status", v, 32'h0);
        check("R1 group lines", 32'(grp_irq), 32'h0);
    endtask

    task automatic t_set_clear;
        logic [31:0] v;
        clean();
        wr(6'h00, 32'h0000_00A5);
        wr(6'h00, 32'h0000_0100);
        rd(6'h00, v); check("R2 set accumulates", v, 32'h0000_01A5);
        rd(6'h04, v); check("R2 readback at 0x4", v, 32'h0000_01A5);
        wr(6'h04, 32'h0000_0005);
        rd(6'h00, v); check("R3 clear selected", v, 32'h0000_01A0);
    endtask

    task automatic t_status_map;
        logic [31:0] v;
        clean();
        wr(6'h00, 32'h0000_0200);
        wr(6'h10, 32'h0000_0004);
        @(negedge clk);
        src_in = '0;
        src_in[9]  = 1'b1;
        src_in[8]  = 1'b1;
        src_in[34] = 1'b1;
        src_in[35] = 1'b1;
        step();
        rd(6'h0C, v); check("R4 bank0 status", v, 32'h0000_0200);
        rd(6'h1C, v); check("R4 bank1 status group4 bit2", v, 32'h0000_0004);
        check("R4 lines for groups 1 and 4", 32'(grp_irq), 32'h0000_0012);
    endtask

    task automatic t_level;
        clean();
        wr(6'h10, 32'h0000_00FF);
        @(negedge clk);
        src_in[33] = 1'b1;
        #1 check("R5 line waits for edge", 32'(grp_irq), 32'h0);
        step();
        check("R5 line rises at edge", 32'(grp_irq[4]), 32'h1);
        repeat (5) @(posedge clk);
        #1 check("R6 held source keeps line", 32'(grp_irq[4]), 32'h1);
        check("R8 only group4 line", 32'(grp_irq), 32'h0000_0010);
        @(negedge clk);
        src_in[33] = 1'b0;
        step();
        check("R6 line falls after release", 32'(grp_irq), 32'h0);
    endtask

    task automatic t_group_clear;
        logic [31:0] v;
        clean();
        wr(6'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        src_in[15:0] = 16'hFFFF;
        step();
        check("R7 before clear", 32'(grp_irq), 32'h0000_0003);
        wr(6'h04, 32'h0000_FF00);
        rd(6'h00, v); check("R7 group1 lane cleared", v, 32'hFFFF_00FF);
        check("R7 group1 line dropped", 32'(grp_irq), 32'h0000_0001);
    endtask

    task automatic t_unused;
        logic [31:0] v;
        clean();
        wr(6'h00, 32'h0000_0011);
        wr(6'h08, 32'hFFFF_FFFF);
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h01, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h34, 32'hFFFF_FFFF);
        rd(6'h00, v); check("R9 enables untouched", v, 32'h0000_0011);
        rd(6'h10, v); check("R9 bank1 untouched", v, 32'h0);
        rd(6'h08, v); check("R9 offset 0x8 reads zero", v, 32'h0);
        rd(6'h01, v); check("R9 unaligned reads zero", v, 32'h0);
        rd(6'h20, v); check("R9 missing bank reads zero", v, 32'h0);
    endtask

    task automatic t_partial;
        logic [31:0] v;
        clean();
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, v); check("R10 only two lanes settable", v, 32'h0000_FFFF);
        @(negedge clk);
        src_in = '1;
        step();
        rd(6'h1C, v); check("R10 status of partial bank", v, 32'h0000_FFFF);
        check("R10 lines groups 4 and 5", 32'(grp_irq), 32'h0000_0030);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_status_map();
        t_level();
        t_group_clear();
        t_unused();
        t_partial();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule